// File: doc/BRIEF.md
# Frame Buffer Pixel Format Unpacker

This block sits between the frame buffer fetch logic and the palette and colour stages of a display pipeline. It takes 32-bit words from the fetch side over a valid/ready stream and sends out one pixel per clock. Each pixel is either a palette index or a 24-bit direct colour. A 3-bit depth code sets how the word is split. Two ordering controls choose a byte-reversed or a bit-reversed layout inside the word. A red/blue swap control and a 2-bit board mux input decide how 16-bit pixels are read.

The depth code and the ordering and colour controls are captured together with each word as it is accepted. A change to these controls between words is safe and never alters pixels already in flight. Input back-pressure works as follows. `in_ready_o` is low while a word still has pixels to emit. It goes high again in the cycle that emits the last pixel of that word, so the next word can be taken in that same cycle. The pixel output has no stall input. Downstream logic must accept one pixel on every cycle in which `pix_valid_o` is high.

A separate combinational output gives the number of bytes one display line occupies. It uses the live column count and the live depth code.

Top module: `pxu_unpacker`

## Requirements
- R1: While `rst_n` is low, `pix_valid_o` is 0 and `in_ready_o` is 1.
- R2: A word is taken on a rising edge where `in_valid_i` and `in_ready_o` are both 1. Its pixels appear on consecutive cycles, starting in the cycle after acceptance. A word gives WORD/d pixels, where d is the slot width; the 12-bit mode uses a 16-bit slot. `in_ready_o` is 0 in every cycle that emits a pixel other than the word's last one.
- R3: Depth codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits and give a palette index. The index is zero-extended to 8 bits in `pix_index_o`, `pix_is_index_o` is 1 and `pix_rgb_o` is 0. In the direct-colour modes `pix_is_index_o` is 0 and `pix_index_o` is 0.
- R4: With both ordering controls clear, pixel i of the word is taken from bits [i*d +: d].
- R5: With `be_byte_i` set, the four bytes of the word are reversed before the split. For depths below 8, pixel i is taken from bits [32-d-i*d +: d], so the first pixel sits at the most significant end.
- R6: With `be_pix_i` set and `be_byte_i` clear, pixels below 8 bits are taken most significant first within each byte, while the bytes keep ascending order. At depths of 8 bits and above this control has no effect.
- R7: Depth code 5 is 32 bits. Red comes from bits 7:0, green from 15:8 and blue from 23:16. `pix_rgb_o` is {red, green, blue}, red in bits 23:16.
- R8: The 5551 layout is red 4:0, green 9:5 and blue 14:10, with bit 15 ignored. The 565 layout is red 4:0, green 10:5 and blue 15:11. Each 5-bit channel is shifted left by 3 and the 6-bit channel by 2.
- R9: When `HAS_EXT` is 1, depth code 7 is 12 bits in a 16-bit slot: red 3:0, green 7:4 and blue 11:8, each shifted left by 4.
- R10: `bgr_i` swaps the red and blue bytes of a direct-colour pixel. It does not change a palette index.
- R11: When `HAS_EXT` is 0, depth codes 4, 6 and 7 are all 16-bit and are read under `mux_i`. Value 1 gives 5551 and honours `bgr_i`. Value 3 gives 565 with red and blue always swapped. Values 0 and 2 give 565 and honour `bgr_i`.
- R12: When `HAS_EXT` is 1, `mux_i` has no effect. Depth code 4 is 5551 and code 6 is 565.
- R13: `line_bytes_o` is cols/8, cols/4, cols/2, cols and cols*4 for depth codes 0, 1, 2, 3 and 5. It is cols*2 for codes 4, 6 and 7.
- R14: A change to the depth, ordering, swap or mux inputs after a word has been accepted does not affect that word's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Block can take a word |
| in_word_i | input | 32 | Frame buffer word |
| depth_i | input | 3 | Depth code |
| bgr_i | input | 1 | Red/blue swap for direct colour |
| be_byte_i | input | 1 | Byte-reversed word order |
| be_pix_i | input | 1 | Most-significant-first pixels within a byte |
| mux_i | input | 2 | Board mux for 16-bit layout (base variant) |
| cols_i | input | COL_W | Columns per line |
| line_bytes_o | output | COL_W+2 | Bytes per line |
| pix_valid_o | output | 1 | Pixel valid |
| pix_is_index_o | output | 1 | Pixel is a palette index |
| pix_index_o | output | 8 | Palette index |
| pix_rgb_o | output | 24 | Direct colour {R,G,B} |

## Verification
The block can emit the last pixel of one word and accept the next word, together with new control values, in the same cycle. The bench provokes this in two ways. It holds `in_valid_i` high with a second word and a different depth while an 8-bit word drains. It also streams 32-bit words back to back, so that each cycle both emits and accepts. The results are judged on gap-free pixel output, on each word decoding under its own captured controls, and on `in_ready_o` rising exactly in the last-pixel cycle. The two variants run in lockstep on identical inputs, so the mux-dependent 16-bit decoding is compared side by side.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int WORD_BITS = 32;
  localparam int BYTES     = WORD_BITS / 8;
  localparam int POS_BITS  = $clog2(WORD_BITS);
  localparam int IDX_BITS  = 8;
  localparam int RGB_BITS  = 24;
  localparam int RAW_BITS  = 24;

  typedef enum logic [2:0] {
    CF_INDEX,
    CF_5551,
    CF_565,
    CF_444,
    CF_888
  } cfmt_e;

  typedef struct packed {
    logic [2:0] lg;          // log2 of slot width
    cfmt_e      cf;
    logic       swap_rb;
    logic       be_byte;
    logic       rev_in_byte;
  } fmt_t;
endpackage

// File: rtl/pxu_fmt_decode.sv
module pxu_fmt_decode
  import pxu_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic [2:0] code_i,
  input  logic       bgr_i,
  input  logic       be_byte_i,
  input  logic       be_pix_i,
  input  logic [1:0] mux_i,
  output fmt_t       fmt_o
);
  cfmt_e cf16;
  logic  sw16;

  generate
    if (HAS_EXT) begin : g_ext
      // layout comes straight from the code; board mux is not consulted
      logic unused_mux;
      assign unused_mux = ^mux_i;
      always_comb begin
        sw16 = bgr_i;
        case (code_i)
          3'd6:    cf16 = CF_565;
          3'd7:    cf16 = CF_444;
          default: cf16 = CF_5551;
        endcase
      end
    end else begin : g_base
      always_comb begin
        case (mux_i)
          2'd1: begin
            cf16 = CF_5551;
            sw16 = bgr_i;
          end
          2'd3: begin
            cf16 = CF_565;
            sw16 = 1'b1;
          end
          default: begin
            cf16 = CF_565;
            sw16 = bgr_i;
          end
        endcase
      end
    end
  endgenerate

  always_comb begin
    fmt_o.be_byte     = be_byte_i;
    fmt_o.rev_in_byte = be_byte_i | be_pix_i;
    fmt_o.swap_rb     = bgr_i;
    case (code_i)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        fmt_o.lg = code_i;
        fmt_o.cf = CF_INDEX;
      end
      3'd5: begin
        fmt_o.lg = 3'd5;
        fmt_o.cf = CF_888;
      end
      default: begin
        fmt_o.lg      = 3'd4;
        fmt_o.cf      = cf16;
        fmt_o.swap_rb = sw16;
      end
    endcase
  end
endmodule

// File: rtl/pxu_pixel_select.sv
module pxu_pixel_select
  import pxu_pkg::*;
(
  input  logic [WORD_BITS-1:0] word_i,
  input  logic [2:0]           lg_i,
  input  logic                 be_byte_i,
  input  logic                 rev_in_byte_i,
  input  logic [POS_BITS-1:0]  idx_i,
  output logic [RAW_BITS-1:0]  raw_o
);
  logic [WORD_BITS-1:0] swapped;
  logic [WORD_BITS-1:0] src;
  logic [POS_BITS-1:0]  lin;
  logic [POS_BITS-1:0]  pos;
  logic [3:0]           dsub;

  genvar b;
  generate
    for (b = 0; b < BYTES; b++) begin : g_swap
      assign swapped[8*b +: 8] = word_i[WORD_BITS-8-8*b +: 8];
    end
  endgenerate

  always_comb begin
    lin  = POS_BITS'(idx_i << lg_i);
    dsub = 4'(4'd1 << lg_i[1:0]);
    if (rev_in_byte_i && (lg_i < 3'd3)) begin
      // mirror the slot inside its byte
      pos = {lin[POS_BITS-1:3], 3'(4'd8 - dsub - {1'b0, lin[2:0]})};
    end else begin
      pos = lin;
    end
    src   = be_byte_i ? swapped : word_i;
    raw_o = RAW_BITS'(src >> pos);
  end
endmodule

// File: rtl/pxu_color_expand.sv
module pxu_color_expand
  import pxu_pkg::*;
(
  input  logic [RAW_BITS-1:0] raw_i,
  input  cfmt_e               cf_i,
  input  logic                swap_i,
  input  logic [1:0]          lg_i,
  output logic                is_index_o,
  output logic [IDX_BITS-1:0] index_o,
  output logic [RGB_BITS-1:0] rgb_o
);
  logic [7:0] r, g, b;
  logic [3:0] dbits;
  logic [7:0] mask;

  always_comb begin
    dbits      = 4'(4'd1 << lg_i);
    mask       = 8'((9'd1 << dbits) - 9'd1);
    is_index_o = 1'b0;
    index_o    = '0;
    r          = '0;
    g          = '0;
    b          = '0;
    case (cf_i)
      CF_INDEX: begin
        is_index_o = 1'b1;
        index_o    = raw_i[7:0] & mask;
      end
      CF_5551: begin
        r = {raw_i[4:0],   3'b000};
        g = {raw_i[9:5],   3'b000};
        b = {raw_i[14:10], 3'b000};
      end
      CF_565: begin
        r = {raw_i[4:0],   3'b000};
        g = {raw_i[10:5],  2'b00};
        b = {raw_i[15:11], 3'b000};
      end
      CF_444: begin
        r = {raw_i[3:0],  4'b0000};
        g = {raw_i[7:4],  4'b0000};
        b = {raw_i[11:8], 4'b0000};
      end
      default: begin
        r = raw_i[7:0];
        g = raw_i[15:8];
        b = raw_i[23:16];
      end
    endcase
    rgb_o = swap_i ? {b, g, r} : {r, g, b};
  end
endmodule

// File: rtl/pxu_line_bytes.sv
module pxu_line_bytes #(
  parameter int COL_W = 12
) (
  input  logic [2:0]       code_i,
  input  logic [COL_W-1:0] cols_i,
  output logic [COL_W+1:0] bytes_o
);
  localparam int OUT_W = COL_W + 2;
  logic [OUT_W-1:0] ext;

  always_comb begin
    ext = {2'b00, cols_i};
    case (code_i)
      3'd0:    bytes_o = ext >> 3;
      3'd1:    bytes_o = ext >> 2;
      3'd2:    bytes_o = ext >> 1;
      3'd3:    bytes_o = ext;
      3'd5:    bytes_o = ext << 2;
      default: bytes_o = ext << 1;
    endcase
  end
endmodule

// File: rtl/pxu_unpacker.sv
module pxu_unpacker
  import pxu_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1,
  parameter int COL_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [WORD_BITS-1:0] in_word_i,
  input  logic [2:0]           depth_i,
  input  logic                 bgr_i,
  input  logic                 be_byte_i,
  input  logic                 be_pix_i,
  input  logic [1:0]           mux_i,
  input  logic [COL_W-1:0]     cols_i,
  output logic [COL_W+1:0]     line_bytes_o,
  output logic                 pix_valid_o,
  output logic                 pix_is_index_o,
  output logic [IDX_BITS-1:0]  pix_index_o,
  output logic [RGB_BITS-1:0]  pix_rgb_o
);
  fmt_t                 fmt_now;
  fmt_t                 fmt_q;
  logic [WORD_BITS-1:0] word_q;
  logic                 busy_q;
  logic [POS_BITS-1:0]  idx_q;
  logic [POS_BITS-1:0]  idx_last;
  logic                 at_last;
  logic                 accept;
  logic [RAW_BITS-1:0]  raw;

  pxu_fmt_decode #(.HAS_EXT(HAS_EXT)) u_dec (
    .code_i    (depth_i),
    .bgr_i     (bgr_i),
    .be_byte_i (be_byte_i),
    .be_pix_i  (be_pix_i),
    .mux_i     (mux_i),
    .fmt_o     (fmt_now)
  );

  assign idx_last   = POS_BITS'((WORD_BITS - 1) >> fmt_q.lg);
  assign at_last    = busy_q && (idx_q == idx_last);
  assign in_ready_o = !busy_q || at_last;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      fmt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      word_q <= in_word_i;
      fmt_q  <= fmt_now;
    end else if (at_last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  pxu_pixel_select u_sel (
    .word_i        (word_q),
    .lg_i          (fmt_q.lg),
    .be_byte_i     (fmt_q.be_byte),
    .rev_in_byte_i (fmt_q.rev_in_byte),
    .idx_i         (idx_q),
    .raw_o         (raw)
  );

  pxu_color_expand u_exp (
    .raw_i      (raw),
    .cf_i       (fmt_q.cf),
    .swap_i     (fmt_q.swap_rb),
    .lg_i       (fmt_q.lg[1:0]),
    .is_index_o (pix_is_index_o),
    .index_o    (pix_index_o),
    .rgb_o      (pix_rgb_o)
  );

  pxu_line_bytes #(.COL_W(COL_W)) u_lb (
    .code_i  (depth_i),
    .cols_i  (cols_i),
    .bytes_o (line_bytes_o)
  );

  assign pix_valid_o = busy_q;
endmodule

// File: rtl/pxu_unpacker_chk.sv
module pxu_unpacker_chk #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [2:0]       depth_i,
  input logic [COL_W-1:0] cols_i,
  input logic [COL_W+1:0] line_bytes_o,
  input logic             pix_valid_o,
  input logic             pix_is_index_o,
  input logic [7:0]       pix_index_o,
  input logic [23:0]      pix_rgb_o
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pix_valid_o && in_ready_o));

  // R2
  stall_means_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready_o |-> pix_valid_o);

  // R2
  accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> pix_valid_o);

  // R2
  word_not_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !in_ready_o) |=> pix_valid_o);

  // R3
  index_no_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && pix_is_index_o) |-> (pix_rgb_o == 24'h0));

  // R3
  rgb_no_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_is_index_o) |-> (pix_index_o == 8'h0));

  // R13
  lb_byte_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_i == 3'd3) |-> (line_bytes_o == {2'b00, cols_i}));

  // R13
  lb_word_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_i == 3'd5) |-> (line_bytes_o == {cols_i, 2'b00}));
endmodule

bind pxu_unpacker pxu_unpacker_chk #(.COL_W(COL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid_i     (in_valid_i),
  .in_ready_o     (in_ready_o),
  .depth_i        (depth_i),
  .cols_i         (cols_i),
  .line_bytes_o   (line_bytes_o),
  .pix_valid_o    (pix_valid_o),
  .pix_is_index_o (pix_is_index_o),
  .pix_index_o    (pix_index_o),
  .pix_rgb_o      (pix_rgb_o)
);

// File: tb/tb_pxu_unpacker.sv
module tb_pxu_unpacker;
  localparam int COL_W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             in_valid;
  logic [31:0]      in_word;
  logic [2:0]       depth;
  logic             bgr, beb, bep;
  logic [1:0]       mux;
  logic [COL_W-1:0] cols;

  logic             rdy_e, pv_e, pi_e;
  logic [COL_W+1:0] lb_e;
  logic [7:0]       idx_e;
  logic [23:0]      rgb_e;
  logic             rdy_b, pv_b, pi_b;
  logic [COL_W+1:0] lb_b;
  logic [7:0]       idx_b;
  logic [23:0]      rgb_b;

  pxu_unpacker #(.HAS_EXT(1'b1), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy_e),
    .in_word_i(in_word), .depth_i(depth), .bgr_i(bgr), .be_byte_i(beb),
    .be_pix_i(bep), .mux_i(mux), .cols_i(cols), .line_bytes_o(lb_e),
    .pix_valid_o(pv_e), .pix_is_index_o(pi_e), .pix_index_o(idx_e),
    .pix_rgb_o(rgb_e)
  );

  pxu_unpacker #(.HAS_EXT(1'b0), .COL_W(COL_W)) dut_base (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy_b),
    .in_word_i(in_word), .depth_i(depth), .bgr_i(bgr), .be_byte_i(beb),
    .be_pix_i(bep), .mux_i(mux), .cols_i(cols), .line_bytes_o(lb_b),
    .pix_valid_o(pv_b), .pix_is_index_o(pi_b), .pix_index_o(idx_b),
    .pix_rgb_o(rgb_b)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cfg: [2:0] depth code, [3] bgr, [4] byte reverse, [5] pixel reverse, [7:6] mux
  task automatic apply_cfg(input logic [7:0] c);
    depth = c[2:0];
    bgr   = c[3];
    beb   = c[4];
    bep   = c[5];
    mux   = c[7:6];
  endtask

  function automatic int npix(input logic [2:0] code);
    case (code)
      3'd0: return 32;
      3'd1: return 16;
      3'd2: return 8;
      3'd3: return 4;
      3'd5: return 1;
      default: return 2;
    endcase
  endfunction

  // returns {is_index, index[7:0], rgb[23:0]}
  function automatic logic [32:0] model(input logic [31:0] w, input logic [7:0] c,
                                        input bit ext, input int i);
    logic [2:0]  code = c[2:0];
    logic [1:0]  m    = c[7:6];
    int          d, pos, per, kind;
    logic [31:0] ww, raw;
    logic [7:0]  r, g, b;
    logic        sw;
    case (code)
      3'd0: d = 1;
      3'd1: d = 2;
      3'd2: d = 4;
      3'd3: d = 8;
      3'd5: d = 32;
      default: d = 16;
    endcase
    if (d < 8) begin
      if (c[4]) pos = 32 - d - i * d;
      else if (c[5]) begin
        per = 8 / d;
        pos = (i / per) * 8 + 8 - d - (i % per) * d;
      end else pos = i * d;
      raw = (w >> pos) & ((32'd1 << d) - 32'd1);
    end else begin
      ww  = c[4] ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
      raw = ww >> (i * d);
      if (d == 8) raw = raw & 32'hFF;
      else if (d == 16) raw = raw & 32'hFFFF;
    end
    if (code <= 3'd3) return {1'b1, raw[7:0], 24'h0};
    sw = c[3];
    if (code == 3'd5) begin
      r = raw[7:0]; g = raw[15:8]; b = raw[23:16];
    end else begin
      if (ext) kind = (code == 3'd4) ? 0 : ((code == 3'd6) ? 1 : 2);
      else begin
        kind = (m == 2'd1) ? 0 : 1;
        if (m == 2'd3) sw = 1'b1;
      end
      case (kind)
        0: begin r = {raw[4:0], 3'b0}; g = {raw[9:5], 3'b0};  b = {raw[14:10], 3'b0}; end
        1: begin r = {raw[4:0], 3'b0}; g = {raw[10:5], 2'b0}; b = {raw[15:11], 3'b0}; end
        default: begin r = {raw[3:0], 4'b0}; g = {raw[7:4], 4'b0}; b = {raw[11:8], 4'b0}; end
      endcase
    end
    if (sw) return {1'b0, 8'h0, b, g, r};
    return {1'b0, 8'h0, r, g, b};
  endfunction

  task automatic check_pix(input string tag, input logic [31:0] w, input logic [7:0] c, input int i);
    chk({tag, " ext"},  {30'h0, pv_e, pi_e, idx_e, rgb_e}, {30'h0, 1'b1, model(w, c, 1'b1, i)});
    chk({tag, " base"}, {30'h0, pv_b, pi_b, idx_b, rgb_b}, {30'h0, 1'b1, model(w, c, 1'b0, i)});
  endtask

  // called at a falling edge with the block idle; returns at a falling edge, idle
  task automatic run_word(input string tag, input logic [31:0] w, input logic [7:0] c,
                          input bit scramble);
    int n;
    n = npix(c[2:0]);
    apply_cfg(c);
    in_word  = w;
    in_valid = 1'b1;
    #1;
    chk("R2 ready when idle", {63'h0, rdy_e & rdy_b}, 64'h1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (scramble) apply_cfg(8'($urandom)); // R14: late control changes
    for (int i = 0; i < n; i++) begin
      check_pix(tag, w, c, i);
      if (i == n - 1 || i == 0)
        chk("R2 ready low until last", {62'h0, rdy_e, rdy_b}, (i == n - 1) ? 64'h3 : 64'h0);
      if (i < n - 1) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2 idle after word", {62'h0, pv_e, pv_b}, 64'h0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb;
    logic [7:0]  ca, cb;
    logic [31:0] ws [3];
    void'($urandom(32'd4711));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    apply_cfg(8'h0);
    cols     = 12'd640;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {60'h0, pv_e, pv_b, rdy_e, rdy_b}, 64'h3);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 little-endian bytes and sub-byte
    run_word("R4 le 8bpp", 32'h44332211, 8'h03, 1'b0);
    run_word("R4 le 1bpp", 32'h8000_0001, 8'h00, 1'b0);
    run_word("R3 le 2bpp index", 32'hE4E4_1B1B, 8'h01, 1'b0);
    // R5 byte reversal
    run_word("R5 be 8bpp", 32'h44332211, 8'h13, 1'b0);
    run_word("R5 be 1bpp", 32'h8000_0003, 8'h10, 1'b0);
    run_word("R5 be 16bpp", 32'h1234_ABCD, 8'h14, 1'b0);
    // R6 pixel reversal within byte
    run_word("R6 rev 4bpp", 32'h0000_12A5, 8'h22, 1'b0);
    run_word("R6 no effect 8bpp", 32'h44332211, 8'h23, 1'b0);
    // R7 and R10 32-bit
    run_word("R7 rgb888", 32'h00CC_BBAA, 8'h05, 1'b0);
    run_word("R10 bgr888", 32'h00CC_BBAA, 8'h0D, 1'b0);
    run_word("R10 bgr index", 32'h44332211, 8'h0B, 1'b0);
    // R8 5551 and 565, R12 mux ignored on ext, R11 base mux decode
    run_word("R8 R11 5551 mux1", 32'h7FFF_801F, 8'h44, 1'b0);
    run_word("R11 R12 mux3", 32'hF800_001F, 8'hC4, 1'b0);
    run_word("R11 mux0 bgr", 32'h07E0_F81F, 8'h0C, 1'b0);
    run_word("R8 565 code6", 32'h07E0_F81F, 8'h86, 1'b0);
    // R9 12-bit
    run_word("R9 444", 32'h0ABC_0123, 8'h07, 1'b0);
    run_word("R9 444 bgr", 32'h0ABC_0123, 8'h0F, 1'b0);

    // R13 line bytes
    cols = 12'd640;
    for (int k = 0; k < 8; k++) begin
      int exp_lb;
      depth = 3'(k);
      #1;
      case (k)
        0: exp_lb = 80;
        1: exp_lb = 160;
        2: exp_lb = 320;
        3: exp_lb = 640;
        5: exp_lb = 2560;
        default: exp_lb = 1280;
      endcase
      chk("R13 line bytes", {36'h0, lb_e, lb_b}, {36'h0, 14'(exp_lb), 14'(exp_lb)});
    end
    cols  = 12'd4095;
    depth = 3'd5;
    #1;
    chk("R13 line bytes max", {50'h0, lb_e}, {50'h0, 14'd16380});
    @(negedge clk);

    // R2 R14: next word waits while current drains, taken on last-pixel cycle
    wa = 32'hDDCC_BBAA; ca = 8'h03;
    wb = 32'h0012_3456; cb = 8'h0D;
    apply_cfg(ca);
    in_word  = wa;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_word = wb;
    apply_cfg(cb);
    for (int i = 0; i < 4; i++) begin
      check_pix("R14 held word A", wa, ca, i);
      chk("R2 backpressure", {62'h0, rdy_e, rdy_b}, (i == 3) ? 64'h3 : 64'h0);
      if (i < 3) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_pix("R2 R14 word B after A", wb, cb, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 idle after B", {62'h0, pv_e, pv_b}, 64'h0);

    // R2 back-to-back 32-bit words, one per cycle
    ws[0] = 32'h0011_2233; ws[1] = 32'h00AB_CDEF; ws[2] = 32'h0055_AA77;
    apply_cfg(8'h05);
    in_word  = ws[0];
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < 2) in_word = ws[k+1];
      else in_valid = 1'b0;
      check_pix("R2 streaming 32bpp", ws[k], 8'h05, 0);
      chk("R2 ready on every streamed cycle", {62'h0, rdy_e, rdy_b}, 64'h3);
    end
    @(posedge clk);
    @(negedge clk);

    // randomized mix, controls scrambled after acceptance (R14)
    for (int k = 0; k < 400; k++) begin
      run_word("RND R14", $urandom, 8'($urandom), 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule